// File: doc/BRIEF.md
# Asynchronous FIFO Read-Strobe Controller

This block is the host-side sequencer that empties an external peripheral FIFO through an asynchronous parallel read port. A request carries a FIFO address, a word count and a mode. In single mode exactly one word is read. In burst mode up to the requested number of words is read. The block drives the FIFO address, an active-low select, an active-low output enable and an active-low read strobe. It samples the data bus and the peripheral's empty flag. Each word it captures goes out on a valid/ready stream. When the transfer ends, the block reports how many words it actually read.

All timing is counted in system clock cycles. The configuration inputs are sampled when a request is accepted and set the following:
- the minimum strobe-low time;
- the minimum strobe-high time;
- the data-valid delay after the strobe falls;
- the flag-settling delay after the strobe rises.

A value of zero counts as one cycle. An optional tied mode drives output enable and the strobe as one signal. A burst ends early when the peripheral reports empty. A captured word waits in a one-entry buffer, and no new strobe is issued until that buffer has drained.

Top module: `fifo_strobe_reader`

## Requirements
- R1: After reset, select, output enable and strobe are all high (inactive), `req_ready` is 1, `out_valid` is 0 and `done_valid` is 0.
- R2: A transfer starts by driving the request address with select low. Output enable and the strobe go low only while select is low. In untied mode, output enable is low for at least one cycle before each strobe falls. The address stays unchanged while select is low.
- R3: Each strobe-low phase lasts max(L, D+1) cycles, where L is the low-time setting and D the data-valid delay, both taken as at least 1. The word is captured at the end of that phase, so the word on the bus before the delay is never delivered.
- R4: Each strobe-high phase lasts at least H cycles, where H is the high-time setting. The empty flag that decides the next strobe is sampled no sooner than F cycles after the strobe rose, where F is the flag delay.
- R5: With `req_burst`=0 exactly one word is read, whatever `req_count` is, and `done_words` is 1 (0 if the FIFO is empty).
- R6: With `req_burst`=1, up to `req_count` words are read in FIFO order (N, N+1, ...). Select stays low and, in untied mode, output enable stays low for the whole burst.
- R7: If the empty flag is 1 when a strobe would be issued, the transfer ends and `done_words` gives the number of words read. A burst with `req_count`=0 issues no strobe and reports 0.
- R8: At the end of a transfer, output enable goes high one cycle before select goes high. `done_valid` is a one-cycle pulse issued while select is high.
- R9: With `cfg_tied`=1, output enable is low exactly in the cycles in which the strobe is low.
- R10: While `out_valid`=1 and `out_ready`=0, `out_data` holds its value. No strobe starts while a captured word is still waiting. No word is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Controller idle; a request is accepted this cycle |
| req_addr | input | AW | FIFO address for the transfer |
| req_count | input | CW | Burst length in words |
| req_burst | input | 1 | 1 = burst, 0 = single word |
| cfg_lo | input | TW | Minimum strobe-low cycles |
| cfg_hi | input | TW | Minimum strobe-high cycles |
| cfg_dly | input | TW | Data-valid delay after strobe falls |
| cfg_flg | input | TW | Empty-flag settling delay after strobe rises |
| cfg_tied | input | 1 | Drive output enable and strobe as one signal |
| fifo_addr | output | AW | FIFO address to the peripheral |
| fifo_cs_n | output | 1 | Active-low select |
| fifo_oe_n | output | 1 | Active-low output enable |
| fifo_rd_n | output | 1 | Active-low read strobe |
| fifo_data | input | DW | Peripheral data bus |
| fifo_empty | input | 1 | Peripheral FIFO empty flag, active high |
| out_valid | output | 1 | Captured word available |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | DW | Captured word |
| done_valid | output | 1 | One-cycle end-of-transfer pulse |
| done_words | output | CW | Words read in the finished transfer |

## Verification
The bench builds the block with DW=16, AW=2, CW=4, TW=3 and tied mode enabled. The 3-bit timing fields allow a data delay of 5 against a low time of 1, so the low phase is stretched by the delay rather than set by the low time. They also allow a flag delay of 4 against a high time of 1, so sampling the empty flag too early would strobe an empty FIFO. The 4-bit count allows a burst of 8 against a FIFO holding 3 words, which exercises the early end. A single-word request carrying a non-zero count checks that single mode ignores the count.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_SEL  = 3'd1,
      ST_OE   = 3'd2,
      ST_CHK  = 3'd3,
      ST_LOW  = 3'd4,
      ST_HIGH = 3'd5,
      ST_ROE  = 3'd6,
      ST_RCS  = 3'd7
   } rd_state_t;

endpackage

// File: rtl/fsr_timing.sv
module fsr_timing #(
   parameter int TW     = 4,
   parameter bit TIE_EN = 1'b1,
   localparam int LW    = TW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] cfg_lo,
   input  logic [TW-1:0] cfg_hi,
   input  logic [TW-1:0] cfg_dly,
   input  logic [TW-1:0] cfg_flg,
   input  logic          cfg_tied,
   output logic [LW-1:0] lo_len,
   output logic [LW-1:0] hi_len,
   output logic          tied
);

   function automatic logic [LW-1:0] floor1(input logic [TW-1:0] v);
      return (v == '0) ? LW'(1) : LW'(v);
   endfunction

   function automatic logic [LW-1:0] larger(input logic [LW-1:0] a, input logic [LW-1:0] b);
      return (a > b) ? a : b;
   endfunction

   logic [LW-1:0] lo_next;
   logic [LW-1:0] hi_next;

   // low phase must cover the data delay plus the capture edge
   assign lo_next = larger(floor1(cfg_lo), floor1(cfg_dly) + LW'(1));
   // high phase must cover the flag settling time
   assign hi_next = larger(floor1(cfg_hi), floor1(cfg_flg));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_len <= LW'(1);
         hi_len <= LW'(1);
      end else if (load) begin
         lo_len <= lo_next;
         hi_len <= hi_next;
      end
   end

   generate
      if (TIE_EN) begin : g_tie
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    tied <= 1'b0;
            else if (load) tied <= cfg_tied;
         end
      end else begin : g_notie
         logic unused_tie;
         assign unused_tie = cfg_tied;
         assign tied       = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/fsr_skid.sv
module fsr_skid #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   output logic          full,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
      end else begin
         if (push) begin
            out_valid <= 1'b1;
            out_data  <= din;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

   assign full = out_valid;

endmodule

// File: rtl/fsr_seq.sv
module fsr_seq
   import fsr_pkg::*;
#(
   parameter int AW = 2,
   parameter int CW = 8,
   parameter int LW = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [CW-1:0] req_count,
   input  logic          req_burst,
   output logic          load,
   input  logic [LW-1:0] lo_len,
   input  logic [LW-1:0] hi_len,
   input  logic          tied,
   input  logic          fifo_empty,
   input  logic          skid_full,
   output logic          capture,
   output logic [AW-1:0] fifo_addr,
   output logic          fifo_cs_n,
   output logic          fifo_oe_n,
   output logic          fifo_rd_n,
   output logic          done_valid,
   output logic [CW-1:0] done_words
);

   rd_state_t     state;
   logic [LW-1:0] cnt;
   logic [CW-1:0] rem;
   logic [CW-1:0] words;
   logic [AW-1:0] addr_q;
   logic          sel_on;
   logic          oe_held;

   assign req_ready = (state == ST_IDLE);
   assign load      = req_ready && req_valid;
   assign capture   = (state == ST_LOW) && (cnt == LW'(1));

   assign sel_on  = (state != ST_IDLE) && (state != ST_RCS);
   assign oe_held = (state == ST_OE) || (state == ST_CHK) ||
                    (state == ST_LOW) || (state == ST_HIGH);

   assign fifo_addr  = addr_q;
   assign fifo_cs_n  = !sel_on;
   assign fifo_rd_n  = (state != ST_LOW);
   assign fifo_oe_n  = tied ? (state != ST_LOW) : !oe_held;
   assign done_valid = (state == ST_RCS);
   assign done_words = words;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         rem    <= '0;
         words  <= '0;
         addr_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  addr_q <= req_addr;
                  rem    <= req_burst ? req_count : CW'(1);
                  words  <= '0;
                  state  <= ST_SEL;
               end
            end
            ST_SEL:  state <= tied ? ST_CHK : ST_OE;
            ST_OE:   state <= ST_CHK;
            ST_CHK: begin
               if ((rem == '0) || fifo_empty) begin
                  state <= ST_ROE;
               end else if (!skid_full) begin
                  cnt   <= lo_len;
                  state <= ST_LOW;
               end
            end
            ST_LOW: begin
               if (cnt == LW'(1)) begin
                  rem   <= rem - CW'(1);
                  words <= words + CW'(1);
                  cnt   <= hi_len;
                  state <= ST_HIGH;
               end else begin
                  cnt <= cnt - LW'(1);
               end
            end
            ST_HIGH: begin
               if (cnt == LW'(1)) state <= ST_CHK;
               else               cnt   <= cnt - LW'(1);
            end
            ST_ROE:  state <= ST_RCS;
            ST_RCS:  state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/fifo_strobe_reader.sv
module fifo_strobe_reader #(
   parameter int DW     = 16,
   parameter int AW     = 2,
   parameter int CW     = 8,
   parameter int TW     = 4,
   parameter bit TIE_EN = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          req_ready,
   input  logic [AW-1:0] req_addr,
   input  logic [CW-1:0] req_count,
   input  logic          req_burst,
   input  logic [TW-1:0] cfg_lo,
   input  logic [TW-1:0] cfg_hi,
   input  logic [TW-1:0] cfg_dly,
   input  logic [TW-1:0] cfg_flg,
   input  logic          cfg_tied,
   output logic [AW-1:0] fifo_addr,
   output logic          fifo_cs_n,
   output logic          fifo_oe_n,
   output logic          fifo_rd_n,
   input  logic [DW-1:0] fifo_data,
   input  logic          fifo_empty,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data,
   output logic          done_valid,
   output logic [CW-1:0] done_words
);

   localparam int LW = TW + 1;

   generate
      if (DW < 1 || AW < 1 || CW < 2 || TW < 1) begin : g_bad_param
         $error("fifo_strobe_reader: parameter out of range");
      end
   endgenerate

   logic [LW-1:0] lo_len;
   logic [LW-1:0] hi_len;
   logic          tied_q;
   logic          load;
   logic          capture;
   logic          skid_full;

   fsr_timing #(.TW(TW), .TIE_EN(TIE_EN)) u_timing (
      .clk(clk), .rst_n(rst_n), .load(load),
      .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_dly(cfg_dly), .cfg_flg(cfg_flg),
      .cfg_tied(cfg_tied), .lo_len(lo_len), .hi_len(hi_len), .tied(tied_q)
   );

   fsr_seq #(.AW(AW), .CW(CW), .LW(LW)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_count(req_count), .req_burst(req_burst), .load(load),
      .lo_len(lo_len), .hi_len(hi_len), .tied(tied_q),
      .fifo_empty(fifo_empty), .skid_full(skid_full), .capture(capture),
      .fifo_addr(fifo_addr), .fifo_cs_n(fifo_cs_n), .fifo_oe_n(fifo_oe_n),
      .fifo_rd_n(fifo_rd_n), .done_valid(done_valid), .done_words(done_words)
   );

   fsr_skid #(.DW(DW)) u_skid (
      .clk(clk), .rst_n(rst_n), .push(capture), .din(fifo_data),
      .full(skid_full), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data)
   );

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker #(
   parameter int DW = 16,
   parameter int AW = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cs_n,
   input logic          oe_n,
   input logic          rd_n,
   input logic [AW-1:0] addr,
   input logic          tied,
   input logic          out_valid,
   input logic          out_ready,
   input logic [DW-1:0] out_data,
   input logic          done_valid
);

   // R2
   oe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !oe_n |-> !cs_n);

   // R2
   strobe_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !cs_n);

   // R2
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_n && !$past(cs_n)) |-> $stable(addr));

   // R2
   oe_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tied && $fell(rd_n)) |-> !$past(oe_n));

   // R8
   oe_off_before_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> $past(oe_n));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |=> !done_valid);

   // R8
   done_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_valid |-> cs_n);

   // R10
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R10
   no_strobe_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rd_n) |-> !$past(out_valid));

endmodule

bind fifo_strobe_reader fsr_checker #(.DW(DW), .AW(AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(fifo_cs_n), .oe_n(fifo_oe_n),
   .rd_n(fifo_rd_n), .addr(fifo_addr), .tied(tied_q),
   .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
   .done_valid(done_valid)
);

// File: tb/sim_fifo_strobe_reader.sv
`timescale 1ns/1ps
module sim_fifo_strobe_reader;

   localparam int DW = 16;
   localparam int AW = 2;
   localparam int CW = 4;
   localparam int TW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [CW-1:0] req_count = '0;
   logic          req_burst = 1'b0;
   logic [TW-1:0] cfg_lo = 3'd1, cfg_hi = 3'd1, cfg_dly = 3'd1, cfg_flg = 3'd1;
   logic          cfg_tied = 1'b0;
   logic [AW-1:0] fifo_addr;
   logic          fifo_cs_n, fifo_oe_n, fifo_rd_n;
   logic [DW-1:0] fifo_data;
   logic          fifo_empty;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [DW-1:0] out_data;
   logic          done_valid;
   logic [CW-1:0] done_words;

   always #5 clk = ~clk;

   fifo_strobe_reader #(.DW(DW), .AW(AW), .CW(CW), .TW(TW), .TIE_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_count(req_count), .req_burst(req_burst),
      .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .cfg_dly(cfg_dly), .cfg_flg(cfg_flg),
      .cfg_tied(cfg_tied), .fifo_addr(fifo_addr), .fifo_cs_n(fifo_cs_n),
      .fifo_oe_n(fifo_oe_n), .fifo_rd_n(fifo_rd_n), .fifo_data(fifo_data),
      .fifo_empty(fifo_empty), .out_valid(out_valid), .out_ready(out_ready),
      .out_data(out_data), .done_valid(done_valid), .done_words(done_words)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- peripheral FIFO model ----------------
   logic [DW-1:0] mem [16];
   int            fill = 0;
   bit            reload = 1'b0;
   int            cur_lo = 1, cur_hi = 1, cur_dly = 1, cur_flg = 1, cur_addr = 0;
   bit            cur_tied = 1'b0;
   int            ptr = 0, ft = 0, lowcnt = 0, hicnt = 0, strobes = 0;
   bit            had_rise = 1'b0;
   logic          empty_r = 1'b1;
   logic [DW-1:0] bus = 16'hA5A5;
   logic          prev_rd = 1'b1, prev_oe = 1'b1, prev_cs = 1'b1;

   assign fifo_empty = empty_r;
   assign fifo_data  = fifo_oe_n ? 16'hF00F : bus;

   always @(negedge clk) begin
      if (reload) begin
         ptr = 0; ft = 0; lowcnt = 0; hicnt = 0; strobes = 0; had_rise = 1'b0;
         empty_r = (fill == 0);
         bus = 16'hA5A5;
      end else if (rst_n) begin
         if (ft == 1) begin
            empty_r = (ptr >= fill);
            ft = 0;
         end else if (ft > 1) begin
            ft--;
         end
         if (!fifo_rd_n && !fifo_cs_n) begin
            lowcnt++;
            if (lowcnt == cur_dly + 1) bus = (ptr < fill) ? mem[ptr] : 16'hEEEE;
         end
         if (!fifo_oe_n) chk(!fifo_cs_n, "R2 oe low without select", int'(fifo_cs_n), 0);
         if (prev_rd && !fifo_rd_n) begin
            strobes++;
            chk(!fifo_cs_n, "R2 strobe without select", int'(fifo_cs_n), 0);
            chk(int'(fifo_addr) == cur_addr, "R2 address", int'(fifo_addr), cur_addr);
            if (!cur_tied) chk(!prev_oe, "R2 oe before strobe", int'(prev_oe), 0);
            if (had_rise) chk(hicnt >= cur_hi, "R4 strobe high width", hicnt, cur_hi);
         end
         if (cur_tied && (prev_rd != fifo_rd_n))
            chk(fifo_oe_n == fifo_rd_n, "R9 tied oe follows strobe", int'(fifo_oe_n), int'(fifo_rd_n));
         if (!prev_rd && fifo_rd_n) begin
            chk(lowcnt >= cur_lo, "R3 strobe low width", lowcnt, cur_lo);
            chk(lowcnt >= cur_dly + 1, "R3 low covers data delay", lowcnt, cur_dly + 1);
            chk(ptr < fill, "R4 strobe on empty fifo", ptr, fill);
            if (!cur_tied) chk(!prev_oe, "R6 oe held in burst", int'(prev_oe), 0);
            ptr++;
            ft = cur_flg;
            lowcnt = 0;
            hicnt = 1;
            had_rise = 1'b1;
         end else if (fifo_rd_n) begin
            hicnt++;
         end
         if (!prev_cs && fifo_cs_n) begin
            chk(prev_oe, "R8 oe released before select", int'(prev_oe), 1);
            had_rise = 1'b0;
         end
      end
      prev_rd = fifo_rd_n;
      prev_oe = fifo_oe_n;
      prev_cs = fifo_cs_n;
   end

   // ---------------- output stream scoreboard ----------------
   logic [DW-1:0] expq[$];
   int            rdy_mode = 0;
   int            cyc = 0;

   always @(negedge clk) begin
      cyc++;
      out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 4) == 3);
      if (rst_n && out_valid && out_ready) begin
         if (expq.size() == 0) begin
            chk(1'b0, "R10 unexpected word", int'(out_data), 0);
         end else begin
            chk(out_data == expq[0], "R6 word order", int'(out_data), int'(expq[0]));
            void'(expq.pop_front());
         end
      end
   end

   task automatic prep(input int n, input logic [DW-1:0] base);
      @(posedge clk);
      fill = n;
      for (int i = 0; i < 16; i++) mem[i] = base + DW'(i);
      reload = 1'b1;
      @(posedge clk);
      reload = 1'b0;
   endtask

   task automatic xfer(input string tag, input int addr, input int cnt, input bit burst,
                       input int lo, input int hi, input int dly, input int flg,
                       input bit tied);
      int want;
      int waitc;
      want = burst ? cnt : 1;
      if (want > fill) want = fill;
      for (int i = 0; i < want; i++) expq.push_back(mem[i]);
      cur_lo = lo; cur_hi = hi; cur_dly = dly; cur_flg = flg;
      cur_tied = tied; cur_addr = addr;
      @(negedge clk);
      req_addr = AW'(addr); req_count = CW'(cnt); req_burst = burst;
      cfg_lo = TW'(lo); cfg_hi = TW'(hi); cfg_dly = TW'(dly); cfg_flg = TW'(flg);
      cfg_tied = tied;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      waitc = 0;
      while (!done_valid && waitc < 2000) begin
         @(negedge clk);
         waitc++;
      end
      chk(done_valid, {tag, " done seen"}, int'(done_valid), 1);
      chk(int'(done_words) == want, {tag, " done_words"}, int'(done_words), want);
      chk(fifo_cs_n, {tag, " R8 select high at done"}, int'(fifo_cs_n), 1);
      chk(strobes == want, {tag, " strobe count"}, strobes, want);
      waitc = 0;
      while (expq.size() != 0 && waitc < 100) begin
         @(negedge clk);
         waitc++;
      end
      chk(expq.size() == 0, {tag, " R10 all words delivered"}, expq.size(), 0);
      expq.delete();
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(fifo_cs_n && fifo_oe_n && fifo_rd_n, "R1 bus idle in reset", 
          int'({fifo_cs_n, fifo_oe_n, fifo_rd_n}), 7);
      chk(req_ready, "R1 req_ready in reset", int'(req_ready), 1);
      chk(!out_valid && !done_valid, "R1 outputs low in reset",
          int'({out_valid, done_valid}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fifo_cs_n && fifo_oe_n && fifo_rd_n, "R1 bus idle after reset",
          int'({fifo_cs_n, fifo_oe_n, fifo_rd_n}), 7);

      prep(5, 16'h0100);
      xfer("R5 single ignores count", 1, 4, 1'b0, 2, 1, 1, 1, 1'b0);
      prep(6, 16'h0200);
      xfer("R6 burst of 4", 2, 4, 1'b1, 2, 2, 1, 1, 1'b0);
      prep(3, 16'h0300);
      xfer("R3 long data delay", 3, 3, 1'b1, 1, 1, 5, 1, 1'b0);
      prep(3, 16'h0400);
      xfer("R7 R4 early end slow flag", 0, 8, 1'b1, 1, 1, 1, 4, 1'b0);
      prep(2, 16'h0500);
      xfer("R7 zero count burst", 1, 0, 1'b1, 1, 1, 1, 1, 1'b0);
      prep(0, 16'h0600);
      xfer("R7 R5 single on empty", 2, 1, 1'b0, 1, 1, 1, 1, 1'b0);
      prep(4, 16'h0700);
      xfer("R9 tied burst", 3, 4, 1'b1, 3, 1, 2, 2, 1'b1);
      rdy_mode = 1;
      prep(7, 16'h0800);
      xfer("R10 backpressure burst", 2, 6, 1'b1, 1, 1, 1, 1, 1'b0);
      rdy_mode = 0;

      repeat (5) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule